// File: doc/BRIEF.md
# Three-Phase Gate Command Logic with Turn-On Delay

This block sits between a PWM generator and the gate drivers of a three-phase MOSFET bridge. Each of the three legs has one low-side and one high-side switch. For each leg the block receives an active-high low-side command and an active-low high-side command. It decodes them into two gate enables and holds back every rising enable for a programmed number of clock cycles, so that a switch is never turned on while its partner is still switching off. Falling enables are not delayed. Because the low-side command wins over the high-side command, one PWM signal wired to both inputs of a leg drives a complementary half-bridge.

A bypass input removes both the interlock and the delay. Each enable then follows its own command, which lets both switches of a leg conduct together, for example in double-forward or switched-reluctance stages. A disable input and an undervoltage-fault input can arrive from any clock domain. Each passes through a two-stage synchronizer, and while either is active all six enables are forced low and any turn-on that is counting down is abandoned.

Top module: `gate_cmd_deadtime`

## Requirements
- R1: While reset is asserted, and at the first sampling after it is released, all six enables are low.
- R2: The high-side command is active low. With low-side command 0 and high-side command 0 the leg requests high on and low off. With low-side command 0 and high-side command 1 the leg requests both off.
- R3: In normal mode (bypass = 0), a low-side command of 1 requests low on and high off, whatever the high-side command is.
- R4: In bypass mode (bypass = 1), the low request equals the low-side command and the high request equals the inverted high-side command, with no interlock. A request turns its enable on at the first rising edge that samples it, so low-side 1 with high-side 0 gives both enables on.
- R5: Disable is synchronized by two flops. Once disable is sampled high at rising edge k, all six enables are low from edge k+2 on, whatever the other inputs are, for as long as it stays high.
- R6: The undervoltage fault uses the same two-flop path and has the same effect and latency as disable.
- R7: In normal mode, with dead-time count D (10 bits, 0 to 1023), an enable whose request is held turns on at the (D+1)-th rising edge that samples the request. With D = 0 it turns on at the first such edge.
- R8: An enable that is on goes low at the first rising edge that samples its request low, with no added delay.
- R9: If a request drops before its delay has run out, the pending turn-on is cancelled. A later request waits the full D+1 edges again.
- R10: While the synchronized disable or fault is active, all pending delays are cleared. After both are released, every turn-on waits the full delay again.
- R11: At any rising edge where bypass was sampled 0, the low and high enables of a leg are not both on after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_cmd | input | 3 | Low-side command per leg, active high |
| hi_cmd_n | input | 3 | High-side command per leg, active low |
| disable_in | input | 1 | Asynchronous disable, active high |
| uv_fault | input | 1 | Asynchronous undervoltage fault, active high |
| bypass | input | 1 | 1 removes interlock and turn-on delay |
| dead_cnt | input | 10 | Turn-on delay in clock cycles |
| lo_en | output | 3 | Low-side gate enable per leg |
| hi_en | output | 3 | High-side gate enable per leg |

## Verification
The bench goes after the delay boundaries: a count of zero, a small count, and the maximum count. An off-by-one in the counter shows up as an enable rising one edge early or late. It drops a request midway through its delay. A design that failed to reload the counter would then turn on early when the request returns. It asserts disable and fault for several cycles and releases them while commands are still held. A design that kept its counts through the fault, or missed a synchronizer stage, would turn on too early or clear the enables at the wrong edge. It also steps out of bypass with both switches of a leg on. A design whose interlock lags would keep both switches conducting after bypass is sampled low.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
    localparam int unsigned LEGS_DEF = 3;
    localparam int unsigned DT_W_DEF = 10;

    typedef struct packed {
        logic lo;
        logic hi;
    } leg_req_t;
endpackage

// File: rtl/gcd_sync2.sv
module gcd_sync2 #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gcd_leg_decode.sv
module gcd_leg_decode (
    input  logic              lo_cmd,
    input  logic              hi_cmd_n,
    input  logic              kill,
    input  logic              bypass,
    output gcd_pkg::leg_req_t req
);
    logic hi_want;

    always_comb begin
        hi_want = ~hi_cmd_n;
        req     = '0;
        if (kill) begin
            req = '0;
        end else if (bypass) begin
            req.lo = lo_cmd;
            req.hi = hi_want;
        end else begin
            req.lo = lo_cmd;
            req.hi = hi_want & ~lo_cmd;
        end
    end
endmodule

// File: rtl/gcd_ondelay.sv
module gcd_ondelay #(
    parameter int unsigned DT_W = gcd_pkg::DT_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            bypass,
    input  logic [DT_W-1:0] dead,
    output logic            on
);
    typedef struct packed {
        logic [DT_W-1:0] cnt;
        logic            on;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!req) begin
            st_d.on  = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.on) begin
            if (bypass || (st_q.cnt >= dead)) begin
                st_d.on = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on = st_q.on;

    AST_OFF_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !on); // R8
    AST_ON_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on) |-> $past(req)); // R9
    AST_DELAY_AT_LEAST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(on) && !$past(bypass) && ($past(dead) != '0)) |-> $past(req, 2)); // R7
endmodule

// File: rtl/gate_cmd_deadtime.sv
module gate_cmd_deadtime #(
    parameter int unsigned LEGS = gcd_pkg::LEGS_DEF,
    parameter int unsigned DT_W = gcd_pkg::DT_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LEGS-1:0] lo_cmd,
    input  logic [LEGS-1:0] hi_cmd_n,
    input  logic            disable_in,
    input  logic            uv_fault,
    input  logic            bypass,
    input  logic [DT_W-1:0] dead_cnt,
    output logic [LEGS-1:0] lo_en,
    output logic [LEGS-1:0] hi_en
);
    localparam int unsigned N_STOP = 2;

    logic [N_STOP-1:0] stop_sync;
    logic              kill;

    gcd_sync2 #(.W(N_STOP)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({uv_fault, disable_in}),
        .sync_out (stop_sync)
    );

    assign kill = |stop_sync;

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        gcd_pkg::leg_req_t req;

        gcd_leg_decode u_dec (
            .lo_cmd   (lo_cmd[g]),
            .hi_cmd_n (hi_cmd_n[g]),
            .kill     (kill),
            .bypass   (bypass),
            .req      (req)
        );

        gcd_ondelay #(.DT_W(DT_W)) u_lo_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req.lo),
            .bypass (bypass),
            .dead   (dead_cnt),
            .on     (lo_en[g])
        );

        gcd_ondelay #(.DT_W(DT_W)) u_hi_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req.hi),
            .bypass (bypass),
            .dead   (dead_cnt),
            .on     (hi_en[g])
        );
    end

    // Age of the run since reset, saturating; used only to bound $past windows.
    logic [1:0] age_d, age_q;

    always_comb begin
        age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    AST_KILL_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> ((lo_en == '0) && (hi_en == '0))); // R10
    AST_DISABLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd3) && $past(disable_in, 2)) |=> ((lo_en == '0) && (hi_en == '0))); // R5
    AST_UV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd3) && $past(uv_fault, 2)) |=> ((lo_en == '0) && (hi_en == '0))); // R6
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |=> ((lo_en & hi_en) == '0)); // R11
    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |-> ((lo_en == '0) && (hi_en == '0))); // R1
endmodule

// File: tb/gate_cmd_deadtime_bench.sv
`timescale 1ns/1ps
module gate_cmd_deadtime_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] lo_cmd = '0;
    logic [2:0] hi_cmd_n = 3'b111;
    logic       dis = 1'b0;
    logic       uv = 1'b0;
    logic       byp = 1'b0;
    logic [9:0] dead = '0;
    logic [2:0] lo_en, hi_en;

    always #2.5 clk = ~clk;

    gate_cmd_deadtime u_gate_cmd_deadtime (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_cmd     (lo_cmd),
        .hi_cmd_n   (hi_cmd_n),
        .disable_in (dis),
        .uv_fault   (uv),
        .bypass     (byp),
        .dead_cnt   (dead),
        .lo_en      (lo_en),
        .hi_en      (hi_en)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state, stepped once per rising edge
    bit [1:0] m_s1, m_s2;
    int       m_cnt [6];
    bit       m_on  [6];
    bit       prev_byp = 1'b0;

    function automatic bit [5:0] model_out();
        bit [5:0] v;
        for (int i = 0; i < 6; i++) v[i] = m_on[i];
        return v; // [2:0] low, [5:3] high
    endfunction

    task automatic model_step();
        bit kill;
        bit rq [6];
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0;
            for (int i = 0; i < 6; i++) begin m_cnt[i] = 0; m_on[i] = 0; end
            return;
        end
        kill = (m_s2 != 2'b00);
        for (int l = 0; l < 3; l++) begin
            if (kill) begin
                rq[l] = 0; rq[l+3] = 0;
            end else if (byp) begin
                rq[l] = lo_cmd[l]; rq[l+3] = !hi_cmd_n[l];            // R4
            end else begin
                rq[l] = lo_cmd[l]; rq[l+3] = !hi_cmd_n[l] && !lo_cmd[l]; // R2 R3
            end
        end
        for (int i = 0; i < 6; i++) begin
            if (!rq[i]) begin
                m_on[i] = 0; m_cnt[i] = 0;                              // R8 R9
            end else if (!m_on[i]) begin
                if (byp || m_cnt[i] >= int'(dead)) m_on[i] = 1;         // R7
                else m_cnt[i] = m_cnt[i] + 1;
            end
        end
        m_s2 = m_s1;
        m_s1 = {uv, dis};
    endtask

    task automatic check(string tag);
        bit [5:0] exp;
        exp = model_out();
        n_vec++;
        if ({hi_en, lo_en} !== exp) begin
            n_bad++;
            $display("FAIL %s: hi_en=%b lo_en=%b expected hi_en=%b lo_en=%b at %0t",
                     tag, hi_en, lo_en, exp[5:3], exp[2:0], $time);
        end
        if (!prev_byp) begin
            n_vec++;
            if ((lo_en & hi_en) != 3'b000) begin
                n_bad++;
                $display("FAIL R11: both-on mask %b expected 000 at %0t", lo_en & hi_en, $time);
            end
        end
    endtask

    task automatic step(string tag, bit r, bit [2:0] l, bit [2:0] h,
                        bit d, bit u, bit b, bit [9:0] dc);
        @(negedge clk);
        check(tag);
        rst_n = r; lo_cmd = l; hi_cmd_n = h; dis = d; uv = u; byp = b; dead = dc;
        prev_byp = b;
        model_step();
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run still active, expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_step();
        // R1: reset with busy inputs
        for (int i = 0; i < 4; i++) step("R1", 0, 3'b101, 3'b000, 0, 0, 1, 10'd0);
        step("R1", 1, 3'b000, 3'b111, 0, 0, 0, 10'd3);
        step("R1", 1, 3'b000, 3'b111, 0, 0, 0, 10'd3);
        // R7/R2: high requested on all legs, dead 3
        for (int i = 0; i < 7; i++) step("R7", 1, 3'b000, 3'b000, 0, 0, 0, 10'd3);
        // R8: immediate off
        for (int i = 0; i < 3; i++) step("R8", 1, 3'b000, 3'b111, 0, 0, 0, 10'd3);
        // R2: mixed decode
        for (int i = 0; i < 6; i++) step("R2", 1, 3'b000, 3'b101, 0, 0, 0, 10'd1);
        // R3: low overrides high
        for (int i = 0; i < 6; i++) step("R3", 1, 3'b111, 3'b000, 0, 0, 0, 10'd2);
        for (int i = 0; i < 6; i++) step("R3", 1, 3'b010, 3'b000, 0, 0, 0, 10'd2);
        // R9: cancel during delay
        for (int i = 0; i < 3; i++) step("R9", 1, 3'b000, 3'b111, 0, 0, 0, 10'd5);
        for (int i = 0; i < 3; i++) step("R9", 1, 3'b000, 3'b000, 0, 0, 0, 10'd5);
        step("R9", 1, 3'b000, 3'b111, 0, 0, 0, 10'd5);
        for (int i = 0; i < 8; i++) step("R9", 1, 3'b000, 3'b000, 0, 0, 0, 10'd5);
        // R4: bypass, both on with no delay
        for (int i = 0; i < 4; i++) step("R4", 1, 3'b111, 3'b000, 0, 0, 1, 10'd7);
        for (int i = 0; i < 3; i++) step("R4", 1, 3'b011, 3'b110, 0, 0, 1, 10'd7);
        // R11: leaving bypass with both on
        for (int i = 0; i < 4; i++) step("R11", 1, 3'b111, 3'b000, 0, 0, 0, 10'd2);
        // R5 then R10: disable and release
        for (int i = 0; i < 6; i++) step("R5", 1, 3'b000, 3'b000, 0, 0, 0, 10'd2);
        for (int i = 0; i < 5; i++) step("R5", 1, 3'b000, 3'b000, 1, 0, 0, 10'd2);
        step("R10", 1, 3'b000, 3'b000, 1, 0, 0, 10'd2);
        for (int i = 0; i < 8; i++) step("R10", 1, 3'b000, 3'b000, 0, 0, 0, 10'd2);
        // R6: undervoltage, with bypass held to show it still wins
        for (int i = 0; i < 5; i++) step("R6", 1, 3'b111, 3'b000, 0, 1, 1, 10'd0);
        for (int i = 0; i < 6; i++) step("R6", 1, 3'b111, 3'b000, 0, 0, 1, 10'd0);
        // R7 corners: zero, large, maximum
        for (int i = 0; i < 3; i++) step("R7", 1, 3'b000, 3'b111, 0, 0, 0, 10'd0);
        for (int i = 0; i < 4; i++) step("R7", 1, 3'b101, 3'b111, 0, 0, 0, 10'd0);
        step("R7", 1, 3'b000, 3'b111, 0, 0, 0, 10'd40);
        for (int i = 0; i < 45; i++) step("R7", 1, 3'b000, 3'b000, 0, 0, 0, 10'd40);
        step("R7", 1, 3'b000, 3'b111, 0, 0, 0, 10'd1023);
        for (int i = 0; i < 1030; i++) step("R7", 1, 3'b111, 3'b111, 0, 0, 0, 10'd1023);
        // Random mix
        begin
            bit [2:0] l = 0, h = 3'b111;
            bit d = 0, u = 0, b = 0;
            bit [9:0] dc = 10'd2;
            for (int i = 0; i < 3000; i++) begin
                string tag;
                if ($urandom_range(3) == 0) l = 3'($urandom);
                if ($urandom_range(3) == 0) h = 3'($urandom);
                if ($urandom_range(40) == 0) d = !d;
                if ($urandom_range(60) == 0) u = !u;
                if ($urandom_range(50) == 0) b = !b;
                if ($urandom_range(30) == 0)
                    dc = ($urandom_range(5) == 0) ? 10'($urandom_range(12)) : 10'($urandom_range(4));
                if (u) tag = "R6";
                else if (d) tag = "R5";
                else if (b) tag = "R4";
                else tag = "R7";
                step(tag, 1, l, h, d, u, b, dc);
            end
        end
        step("R8", 1, 3'b000, 3'b111, 0, 0, 0, 10'd0);
        step("R8", 1, 3'b000, 3'b111, 0, 0, 0, 10'd0);
        @(negedge clk);
        check("R8");
        finish_run();
    end
endmodule